// File: doc/BRIEF.md
# Hypervisor Maintenance Interrupt Controller

This block is the hypervisor-facing control side of a virtualised interrupt controller that serves up to `NCPU` virtual CPUs. For each CPU it keeps a hypervisor control word and a packed virtual-machine control word. It also takes three per-CPU status vectors from the neighbouring list-register block, each with one bit per list register: occupied, pending and end-of-interrupt requested. From these it derives an end-of-interrupt status vector and an 8-bit maintenance status word for each CPU. It drives one level-sensitive maintenance interrupt per CPU.

Software reaches the registers through a simple single-cycle request port. When address bits above bit 8 are all zero, the requester's own ID selects the bank. When any of those bits is set, they name the target CPU directly and the offset is the address modulo 512. This lets one CPU program another CPU's copy. Read data comes back one cycle after the request. An access that is not decoded sets a sticky error flag.

Top module: `hyp_maint_ctrl`

## Requirements
- R1: With `req_addr_i[12:9]` equal to zero, an access goes to the bank of the CPU named by `req_id_i`.
- R2: With `req_addr_i[12:9]` nonzero, that field names the target CPU and `req_addr_i[8:0]` is the register offset, whatever `req_id_i` is.
- R3: These cases are errors: a slice index of `NCPU` or more, or an offset outside {0x00, 0x04, 0x08, 0x10, 0x20, 0x24, 0x30, 0x34, 0xF0}. An erroneous read returns 0, an erroneous write changes no state, and `dec_err_o` goes to 1 after the edge and stays at 1 until reset.
- R4: The hypervisor control word at offset 0x00 keeps bits [7:0] and [31:27] and reads back with all other bits zero. The bit meanings are: [0] enable, [1] underflow interrupt enable, [2] list-entry-not-present enable, [3] no-pending enable, [4] group0-enabled, [5] group0-disabled, [6] group1-enabled, [7] group1-disabled, [31:27] EOI count.
- R5: The VM control word at 0x08 holds these fields: priority mask [31:27], binary point [23:21], aliased binary point [20:18], EOI mode [9], CBPR [4], FIQ enable [3], ack control [2], group1 enable [1] and group0 enable [0]. It reads back in that layout with all other bits zero.
- R6: Offset 0x04 reads 0x44000000 OR (`NLR`-1).
- R7: Maintenance status at 0x10, low half. Bit0 is set when any end-of-interrupt status bit is set. Bit1 is set when control bit1 is set and at most one list register is occupied. Bit2 is set when control bit2 is set and the EOI count is nonzero. Bit3 is set when control bit3 is set and no list register is pending.
- R8: Maintenance status, high half. Bit4 is control[4] AND group0 enable. Bit5 is control[5] AND NOT group0 enable. Bit6 is control[6] AND group1 enable. Bit7 is control[7] AND NOT group1 enable.
- R9: `maint_o[c]` is registered. After each edge it equals the control enable bit of CPU c AND (its maintenance status is nonzero), both evaluated before that edge.
- R10: End-of-interrupt status bit i is set when list register i is not occupied and requests end-of-interrupt. It reads at 0x20 (bits 31:0) and 0x24 (bits 63:32). Empty status has a 1 for each list register that is not occupied. It reads at 0x30 (bits 31:0) and 0x34 (bits 63:32). Bits at or above `NLR` read as 0.
- R11: Offset 0xF0 reads as 0, a write to it has no effect, and it raises no error.
- R12: A read request gives `rsp_valid_o`=1 with its data in the next cycle. Writes and idle cycles give `rsp_valid_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Register access request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | AW | Byte address: [AW-1:9] slice, [8:0] offset |
| req_wdata_i | input | 32 | Write data |
| req_id_i | input | IDW | Requesting CPU ID |
| lr_valid_i | input | NCPU*NLR | Per-CPU list-register occupied flags, CPU c at [c*NLR +: NLR] |
| lr_pend_i | input | NCPU*NLR | Per-CPU list-register pending flags |
| lr_eoi_i | input | NCPU*NLR | Per-CPU list-register end-of-interrupt request flags |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_rdata_o | output | 32 | Read data |
| dec_err_o | output | 1 | Sticky decode error |
| maint_o | output | NCPU | Maintenance interrupt per CPU |

## Verification
Read data and the error flag are due one edge after the request cycle. A maintenance interrupt is due one edge after the state it reflects, and that state includes the list-register inputs present at that edge. A write therefore affects `maint_o` only after a second edge. The bench drives a request on the falling edge and lets one rising edge pass. At the next falling edge it compares every output against a behavioural model. The model computed its expectations from its state before it applied the same write, so each result is checked in exactly the cycle in which it is due.

// File: rtl/hyp_maint_ctrl.sv
module hyp_maint_ctrl #(
  parameter int NCPU = 8,
  parameter int NLR  = 4,
  parameter int AW   = 13,
  localparam int IDW = (NCPU > 1) ? $clog2(NCPU) : 1,
  localparam int LW  = NCPU * NLR
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid_i,
  input  logic            req_write_i,
  input  logic [AW-1:0]   req_addr_i,
  input  logic [31:0]     req_wdata_i,
  input  logic [IDW-1:0]  req_id_i,
  input  logic [LW-1:0]   lr_valid_i,
  input  logic [LW-1:0]   lr_pend_i,
  input  logic [LW-1:0]   lr_eoi_i,
  output logic            rsp_valid_o,
  output logic [31:0]     rsp_rdata_o,
  output logic            dec_err_o,
  output logic [NCPU-1:0] maint_o
);
  localparam int SW = AW - 9;
  localparam int TW = (SW > IDW) ? SW : IDW;
  localparam logic [31:0] HCR_MASK  = 32'hF800_00FF;
  localparam logic [31:0] VMCR_MASK = 32'hF8FC_021F;
  localparam logic [31:0] TYPE_VAL  = 32'h4400_0000 | 32'(NLR - 1);

  logic [31:0] hcr_q  [NCPU];
  logic [31:0] vmcr_q [NCPU];
  logic [7:0]  misr   [NCPU];
  logic [NLR-1:0] eisr [NCPU];
  logic [NCPU-1:0] en_vec;

  genvar g;
  generate
    for (g = 0; g < NCPU; g++) begin : g_cpu
      logic [NLR-1:0] v, p, e;
      logic [31:0] h, m;
      assign v = lr_valid_i[g*NLR +: NLR];
      assign p = lr_pend_i[g*NLR +: NLR];
      assign e = lr_eoi_i[g*NLR +: NLR];
      assign h = hcr_q[g];
      assign m = vmcr_q[g];
      assign eisr[g] = e & ~v;
      assign misr[g] = { h[7] & ~m[1],
                         h[6] &  m[1],
                         h[5] & ~m[0],
                         h[4] &  m[0],
                         h[3] & ~(|p),
                         h[2] & (|h[31:27]),
                         h[1] & ((v & (v - 1'b1)) == '0),
                         |eisr[g] };
      assign en_vec[g] = h[0];
    end
  endgenerate

  logic [SW-1:0] slice;
  logic [8:0]    off;
  logic [TW-1:0] tgt;
  logic          bad_cpu, off_ok, acc_err;
  assign slice   = req_addr_i[AW-1:9];
  assign off     = req_addr_i[8:0];
  assign tgt     = (slice != '0) ? TW'(slice) : TW'(req_id_i);
  assign bad_cpu = {{(32-TW){1'b0}}, tgt} >= NCPU;

  always_comb begin
    case (off)
      9'h000, 9'h004, 9'h008, 9'h010, 9'h020,
      9'h024, 9'h030, 9'h034, 9'h0F0: off_ok = 1'b1;
      default:                        off_ok = 1'b0;
    endcase
  end
  assign acc_err = req_valid_i & (bad_cpu | ~off_ok);

  logic [31:0]    hcr_s, vmcr_s;
  logic [7:0]     misr_s;
  logic [NLR-1:0] eisr_s, empty_s;
  always_comb begin
    hcr_s = '0; vmcr_s = '0; misr_s = '0; eisr_s = '0; empty_s = '0;
    for (int c = 0; c < NCPU; c++)
      if (tgt == TW'(c)) begin
        hcr_s   = hcr_q[c];
        vmcr_s  = vmcr_q[c];
        misr_s  = misr[c];
        eisr_s  = eisr[c];
        empty_s = ~lr_valid_i[c*NLR +: NLR];
      end
  end

  logic [63:0] eisr64, empty64;
  assign eisr64  = 64'(eisr_s);
  assign empty64 = 64'(empty_s);

  logic [31:0] rd_mux;
  always_comb begin
    case (off)
      9'h000:  rd_mux = hcr_s;
      9'h004:  rd_mux = TYPE_VAL;
      9'h008:  rd_mux = vmcr_s;
      9'h010:  rd_mux = {24'd0, misr_s};
      9'h020:  rd_mux = eisr64[31:0];
      9'h024:  rd_mux = eisr64[63:32];
      9'h030:  rd_mux = empty64[31:0];
      9'h034:  rd_mux = empty64[63:32];
      default: rd_mux = '0;
    endcase
    if (bad_cpu) rd_mux = '0;
  end

  logic wr_ok;
  assign wr_ok = req_valid_i & req_write_i & ~acc_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCPU; c++) begin
        hcr_q[c]  <= '0;
        vmcr_q[c] <= '0;
      end
      maint_o     <= '0;
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
      dec_err_o   <= 1'b0;
    end else begin
      for (int c = 0; c < NCPU; c++) begin
        maint_o[c] <= en_vec[c] & (|misr[c]);
        if (wr_ok && tgt == TW'(c)) begin
          if (off == 9'h000) hcr_q[c]  <= req_wdata_i & HCR_MASK;
          if (off == 9'h008) vmcr_q[c] <= req_wdata_i & VMCR_MASK;
        end
      end
      rsp_valid_o <= req_valid_i & ~req_write_i;
      rsp_rdata_o <= (req_valid_i & ~req_write_i) ? rd_mux : '0;
      dec_err_o   <= dec_err_o | acc_err;
    end
  end

  p_maint_needs_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (maint_o & ~$past(en_vec)) == '0);
  p_read_answers_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && !req_write_i) |=> rsp_valid_o);
  p_rsp_only_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |-> $past(req_valid_i && !req_write_i));
  p_err_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dec_err_o |=> dec_err_o);
  p_apr_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && $past(req_addr_i[8:0] == 9'h0F0)) |-> rsp_rdata_o == '0);
endmodule

// File: tb/hyp_maint_ctrl_tb_top.sv
module hyp_maint_ctrl_tb_top;
  localparam int NCPU = 8;
  localparam int NLR  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [12:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [2:0]  req_id = '0;
  logic [31:0] lr_v = '0, lr_p = '0, lr_e = '0;
  logic        rsp_valid, dec_err;
  logic [31:0] rsp_rdata;
  logic [7:0]  maint;

  always #10 clk = ~clk;

  hyp_maint_ctrl #(.NCPU(NCPU), .NLR(NLR), .AW(13)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_id_i(req_id),
    .lr_valid_i(lr_v), .lr_pend_i(lr_p), .lr_eoi_i(lr_e),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .dec_err_o(dec_err),
    .maint_o(maint));

  int vecs = 0, errs = 0;
  bit done = 0;
  int unsigned m_hcr [NCPU];
  int unsigned m_vmcr[NCPU];
  bit m_err = 0;

  task automatic chk(string req, longint act, longint exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int unsigned m_misr(int c);
    int unsigned r = 0, h = m_hcr[c], vm = m_vmcr[c];
    int nvalid = 0, npend = 0, neoi = 0;
    for (int i = 0; i < NLR; i++) begin
      if (lr_v[c*NLR+i]) nvalid++;
      if (lr_p[c*NLR+i]) npend++;
      if (lr_e[c*NLR+i] && !lr_v[c*NLR+i]) neoi++;
    end
    if (neoi > 0) r += 1;
    if (h[1] && nvalid <= 1) r += 2;
    if (h[2] && h[31:27] != 0) r += 4;
    if (h[3] && npend == 0) r += 8;
    if (h[4] && vm[0]) r += 16;
    if (h[5] && !vm[0]) r += 32;
    if (h[6] && vm[1]) r += 64;
    if (h[7] && !vm[1]) r += 128;
    return r;
  endfunction

  function automatic int target(int addr, int id);
    return (addr >> 9) != 0 ? (addr >> 9) : id;
  endfunction

  function automatic bit m_bad(int addr, int id);
    int off = addr & 511;
    bit ok = (off == 'h0 || off == 'h4 || off == 'h8 || off == 'h10 ||
              off == 'h20 || off == 'h24 || off == 'h30 || off == 'h34 ||
              off == 'hF0);
    return target(addr, id) >= NCPU || !ok;
  endfunction

  function automatic int unsigned m_read(int addr, int id);
    int t = target(addr, id);
    int off = addr & 511;
    int unsigned r = 0;
    if (m_bad(addr, id)) return 0;
    case (off)
      'h0:  r = m_hcr[t];
      'h4:  r = 32'h4400_0000 + NLR - 1;
      'h8:  r = m_vmcr[t];
      'h10: r = m_misr(t);
      'h20: for (int i = 0; i < NLR; i++)
              if (lr_e[t*NLR+i] && !lr_v[t*NLR+i]) r += (1 << i);
      'h30: for (int i = 0; i < NLR; i++)
              if (!lr_v[t*NLR+i]) r += (1 << i);
      default: r = 0;
    endcase
    return r;
  endfunction

  task automatic step(string tag, bit rq, bit w, int addr, int unsigned data, int id);
    bit exp_rv = rq && !w;
    int unsigned exp_rd = exp_rv ? m_read(addr, id) : 0;
    logic [7:0] exp_m;
    for (int c = 0; c < NCPU; c++)
      exp_m[c] = m_hcr[c][0] && (m_misr(c) != 0);
    if (rq) begin
      if (m_bad(addr, id)) m_err = 1;
      else if (w) begin
        if ((addr & 511) == 0) m_hcr[target(addr, id)] = data & 32'hF800_00FF;
        if ((addr & 511) == 8) m_vmcr[target(addr, id)] = data & 32'hF8FC_021F;
      end
    end
    req_valid = rq; req_write = w; req_addr = 13'(addr);
    req_wdata = data; req_id = 3'(id);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0; req_write = 0;
    chk({tag, " R12 rsp_valid"}, rsp_valid, exp_rv);
    if (exp_rv) chk({tag, " rdata"}, rsp_rdata, exp_rd);
    chk("R9 maint", maint, exp_m);
    chk("R3 dec_err", dec_err, m_err);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step("idle", 0, 0, 0, 0, 0);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      errs++; vecs++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NCPU; c++) begin m_hcr[c] = 0; m_vmcr[c] = 0; end
    repeat (3) @(negedge clk);
    chk("reset maint", maint, 0);
    chk("reset R12 rsp_valid", rsp_valid, 0);
    chk("reset R3 dec_err", dec_err, 0);
    rst_n = 1;
    idle(1);

    step("R4 R1 wr hcr", 1, 1, 'h000, 32'hFFFF_FFFF, 2);
    step("R4 R1 rd hcr", 1, 0, 'h000, 0, 2);
    step("R1 other bank", 1, 0, 'h000, 0, 3);
    idle(2);
    lr_v[11:8] = 4'b0011; lr_p[11:8] = 4'b0001; lr_e[11:8] = 4'b0100;
    idle(1);
    step("R7 misr", 1, 0, 'h010, 0, 2);
    step("R10 eoi lo", 1, 0, 'h020, 0, 2);
    step("R10 eoi hi", 1, 0, 'h024, 0, 2);
    step("R10 empty lo", 1, 0, 'h030, 0, 2);
    step("R10 empty hi", 1, 0, 'h034, 0, 2);
    lr_v[11:8] = 4'b0100; lr_p[11:8] = 4'b0000; lr_e[11:8] = 4'b0000;
    step("R7 misr one valid", 1, 0, 'h010, 0, 2);
    step("R5 wr vmcr", 1, 1, 'h008, 32'hFFFF_FFFF, 2);
    step("R5 rd vmcr", 1, 0, 'h008, 0, 2);
    step("R8 misr enabled", 1, 0, 'h010, 0, 2);
    step("R5 wr vmcr g0", 1, 1, 'h008, 32'h0000_0001, 2);
    step("R8 misr g0 only", 1, 0, 'h010, 0, 2);
    step("R5 wr vmcr fields", 1, 1, 'h008, 32'h5A5A_5A5A, 2);
    step("R5 rd vmcr fields", 1, 0, 'h008, 0, 2);

    step("R2 slice wr hcr", 1, 1, 'hA00, 32'h0800_0009, 0);
    step("R2 R1 banked rd", 1, 0, 'h000, 0, 5);
    step("R2 slice rd", 1, 0, 'hA00, 0, 3);
    step("R2 slice vmcr", 1, 1, 'hA08, 32'h0000_0002, 1);
    step("R2 banked vmcr", 1, 0, 'h008, 0, 5);
    step("R2 slice misr", 1, 0, 'hA10, 0, 0);
    lr_p[23:20] = 4'b1000;
    idle(2);

    step("R6 type", 1, 0, 'h004, 0, 0);
    step("R6 type slice", 1, 0, 'hE04, 0, 4);
    step("R11 apr wr", 1, 1, 'h0F0, 32'hFFFF_FFFF, 1);
    step("R11 apr rd", 1, 0, 'h0F0, 0, 1);
    step("R11 hcr untouched", 1, 0, 'h000, 0, 1);

    step("R9 disable", 1, 1, 'h000, 32'h0000_00FE, 2);
    idle(2);
    step("R9 en only", 1, 1, 'h000, 32'h0000_0001, 6);
    idle(2);
    lr_e[24] = 1'b1;
    idle(2);
    lr_v[24] = 1'b1;
    idle(2);
    step("R7 uie two valid", 1, 1, 'h000, 32'h0000_0003, 6);
    lr_v[27:24] = 4'b0011;
    idle(2);
    lr_v[27:24] = 4'b0001;
    idle(2);

    step("R3 bad off", 1, 0, 'h00C, 0, 0);
    step("R3 bad slice wr", 1, 1, 'h1200, 32'h0000_00FF, 0);
    step("R3 cpu1 unchanged", 1, 0, 'h000, 0, 1);
    step("R3 bad slice rd", 1, 0, 'h1E10, 0, 0);
    idle(2);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule